// File: doc/BRIEF.md
# Disk Controller Command Front End

This block is the command and register front end of a disk controller. A host writes one byte at a time, and a command/data select line marks each byte as a command opcode or as register data. The block decodes three commands. Drive select latches the drive number, the drive type and a head-load-delay enable. Drive deselect drops every drive-select line. Set-pointer aims the register pointer at one of the internal registers. Every command, and every completion pulse from the transfer sequencer next to this block, marks the interrupt status as done. A completion pulse can also carry a termination code. When the termination-conditions register enables it, completion raises the interrupt line.

The two output latch images (`sel1_o`, `sel2_o`) feed the auxiliary-bus sequencer, which places them on the external latches. The upper nibble of `sel1_o` is a one-hot drive select. Its lower nibble holds the programmable outputs, copied from the retry register at the moment a drive is selected. Bit 7 of `sel2_o` is an active-low copy of drive-select line 3. The host reads the interrupt status with a command-side read, and that read also clears the pending interrupt.

Top module: `dskc_cmd_front`

## Requirements
- R1: While `rst` is high and after it is released: `sel1_o`=0x00, `sel2_o`=0x80, `irq_o`=0, `dma_busy_o`=0, `reg_ptr_o`=0, `drv_type_o`=0, `hld_en_o`=0. All registers and the interrupt status read as zero.
- R2: A command write with opcode 0x20..0x3F selects a drive. Opcode bits 1:0 give drive d, and `sel1_o` becomes (0x10<<d) OR (retry register bits 3:0). Opcode bits 3:2 appear on `drv_type_o` and bit 4 on `hld_en_o`, one cycle after the write.
- R3: Bit 7 of `sel2_o` is always the complement of bit 7 of `sel1_o`. Bits 6:0 of `sel2_o` stay 0.
- R4: Command 0x01 deselects. It clears `sel1_o` bits 7:4, keeps `sel1_o` bits 3:0 and sets `sel2_o` bit 7. `drv_type_o` and `hld_en_o` are left unchanged.
- R5: A command write with opcode 0x40..0x4F loads `reg_ptr_o` with the low nibble. Values above 10 load 10.
- R6: A data-side write stores the byte in the register at the pointer. Each data-side read or write then advances the pointer by one, and the pointer stays at 10 once it reaches it. Register 8 is the retry register and register 9 is the termination-conditions register.
- R7: Writing the retry register does not change `sel1_o` until the next drive select.
- R8: A data-side read at pointer 8 returns the chip status, with the last selected drive number in bits 1:0 and zeros above. A data-side read at any other pointer returns 0.
- R9: Every command write sets the done bit (0x20) of the interrupt status and leaves its termination code (bits 4:3) unchanged. Other opcodes change no other state.
- R10: A completion pulse with a code replaces bits 4:3 with that code: 0 success, 1 read-ID error, 2 seek error, 3 data error. A completion pulse without a code keeps the old code. Both forms set done.
- R11: At completion, if bit 5 of the termination-conditions register is 1, the pending bit (0x80) and `irq_o` are set. If that bit is 0, they are not set.
- R12: A command-side read returns the interrupt status as it was before the read, on `host_rdata` one cycle later. The read clears the pending bit and `irq_o`. Done and the code are kept.
- R13: `dma_busy_o` stays 0, since no transfer is started by this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_cmd | input | 1 | 1 = command side, 0 = register data side |
| host_wdata | input | 8 | Write byte (opcode or register data) |
| host_rdata | output | 8 | Registered read byte |
| fin_valid | input | 1 | Completion pulse from the transfer sequencer |
| fin_has_code | input | 1 | Completion carries a termination code |
| fin_code | input | 2 | Termination code |
| sel1_o | output | 8 | Drive-select / programmable output latch image |
| sel2_o | output | 8 | Second output latch image, bit 7 active-low drive 3 |
| drv_type_o | output | 2 | Drive type of the last select |
| hld_en_o | output | 1 | Head-load-delay enable of the last select |
| reg_ptr_o | output | PTR_W | Register pointer |
| irq_o | output | 1 | Interrupt request |
| dma_busy_o | output | 1 | DMA-in-progress, held low |

## Verification
The hardest case to reach is the split between how the termination code and the interrupt behave. This needs completion events while the termination-conditions register is both enabled and disabled, with reads of the interrupt status between them. The bench first programs the retry and termination-conditions registers through the pointer and runs a table of opcodes with interrupts enabled. It then disables interrupts by rewriting register 9, and issues completion pulses with and without codes. The stale-retry case is reached by rewriting register 8 while a drive stays selected, then selecting again.

// File: rtl/dskc_pkg.sv
package dskc_pkg;
  typedef enum logic [2:0] {
    CK_OTHER  = 3'd0,
    CK_DESEL  = 3'd1,
    CK_SELECT = 3'd2,
    CK_SETPTR = 3'd3
  } cmd_kind_t;

  typedef struct packed {
    cmd_kind_t  kind;
    logic [1:0] drive;
    logic [1:0] dtype;
    logic       hld;
    logic [3:0] ptr_val;
  } cmd_dec_t;

  localparam int STAT_PEND = 7;
  localparam int STAT_DMA  = 6;
  localparam int STAT_DONE = 5;
endpackage

// File: rtl/dskc_decode.sv
module dskc_decode
  import dskc_pkg::*;
#(
  parameter logic [7:0] DESEL_OP = 8'h01
) (
  input  logic [7:0] op,
  output cmd_dec_t   dec
);
  always_comb begin
    dec.drive   = op[1:0];
    dec.dtype   = op[3:2];
    dec.hld     = op[4];
    dec.ptr_val = op[3:0];
    if (op == DESEL_OP)          dec.kind = CK_DESEL;
    else if (op[7:5] == 3'b001)  dec.kind = CK_SELECT;
    else if (op[7:4] == 4'h4)    dec.kind = CK_SETPTR;
    else                         dec.kind = CK_OTHER;
  end
endmodule

// File: rtl/dskc_regfile.sv
module dskc_regfile #(
  parameter int NREG      = 11,
  parameter int RETRY_IDX = 8,
  parameter int TCOND_IDX = 9,
  localparam int PW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_ptr,
  input  logic [3:0]    ld_val,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [7:0]    wdata,
  output logic [PW-1:0] ptr_o,
  output logic [7:0]    retry_o,
  output logic [7:0]    tcond_o
);
  localparam logic [3:0]    PMAX4 = 4'(NREG - 1);
  localparam logic [PW-1:0] PMAXP = PW'(NREG - 1);

  logic [PW-1:0] ptr_q;
  logic [7:0]    bank [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ld_ptr) begin
      ptr_q <= (ld_val > PMAX4) ? PMAXP : PW'(ld_val);
    end else if ((acc_wr || acc_rd) && ptr_q != PMAXP) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                  bank[i] <= '0;
      else if (acc_wr && ptr_q == PW'(i))       bank[i] <= wdata;
    end
  end

  assign ptr_o   = ptr_q;
  assign retry_o = bank[RETRY_IDX];
  assign tcond_o = bank[TCOND_IDX];

  a_r5_ptr_bound: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PMAXP);
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !ld_ptr && ptr_q == PMAXP) |=> ptr_q == PMAXP);
endmodule

// File: rtl/dskc_status.sv
module dskc_status
  import dskc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       done_evt,
  input  logic       has_code,
  input  logic [1:0] code,
  input  logic       int_en,
  input  logic       rd_clr,
  output logic [7:0] stat_o
);
  logic [7:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (rd_clr) st_d[STAT_PEND] = 1'b0;
    if (done_evt) begin
      st_d[STAT_DONE] = 1'b1;
      if (has_code) st_d[4:3] = code;
      if (int_en)   st_d[STAT_PEND] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign stat_o = st_q;

  a_r9_done_set: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> st_q[STAT_DONE]);
  a_r10_code_kept: assert property (@(posedge clk) disable iff (rst)
    (done_evt && !has_code) |=> st_q[4:3] == $past(st_q[4:3]));
  a_r11_no_irq: assert property (@(posedge clk) disable iff (rst)
    (!(done_evt && int_en) && !st_q[STAT_PEND]) |=> !st_q[STAT_PEND]);
  a_r12_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !done_evt) |=> !st_q[STAT_PEND]);
  a_r13_no_dma: assert property (@(posedge clk) disable iff (rst)
    !st_q[STAT_DMA]);
endmodule

// File: rtl/dskc_cmd_front.sv
module dskc_cmd_front
  import dskc_pkg::*;
#(
  parameter int         NREG      = 11,
  parameter int         RETRY_IDX = 8,
  parameter int         TCOND_IDX = 9,
  parameter int         CHIP_IDX  = 8,
  parameter logic [7:0] DESEL_OP  = 8'h01,
  localparam int        PTR_W     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_cmd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             fin_valid,
  input  logic             fin_has_code,
  input  logic [1:0]       fin_code,
  output logic [7:0]       sel1_o,
  output logic [7:0]       sel2_o,
  output logic [1:0]       drv_type_o,
  output logic             hld_en_o,
  output logic [PTR_W-1:0] reg_ptr_o,
  output logic             irq_o,
  output logic             dma_busy_o
);
  cmd_dec_t   dec;
  logic       cmd_wr, dat_wr, cmd_rd, dat_rd;
  logic [7:0] retry, tcond, stat;
  logic [PTR_W-1:0] ptr;
  logic [7:0] sel1_q, sel2_q, chip_q, rdata_q;
  logic [1:0] type_q;
  logic       hld_q;
  logic [3:0] onehot;

  assign cmd_wr = host_wr &  host_cmd;
  assign dat_wr = host_wr & ~host_cmd;
  assign cmd_rd = host_rd &  host_cmd & ~host_wr;
  assign dat_rd = host_rd & ~host_cmd & ~host_wr;

  dskc_decode #(.DESEL_OP(DESEL_OP)) i_dec (
    .op  (host_wdata),
    .dec (dec)
  );

  dskc_regfile #(.NREG(NREG), .RETRY_IDX(RETRY_IDX), .TCOND_IDX(TCOND_IDX)) i_rf (
    .clk     (clk),
    .rst     (rst),
    .ld_ptr  (cmd_wr && dec.kind == CK_SETPTR),
    .ld_val  (dec.ptr_val),
    .acc_wr  (dat_wr),
    .acc_rd  (dat_rd),
    .wdata   (host_wdata),
    .ptr_o   (ptr),
    .retry_o (retry),
    .tcond_o (tcond)
  );

  dskc_status i_st (
    .clk      (clk),
    .rst      (rst),
    .done_evt (cmd_wr | fin_valid),
    .has_code (fin_valid & fin_has_code),
    .code     (fin_code),
    .int_en   (tcond[STAT_DONE]),
    .rd_clr   (cmd_rd),
    .stat_o   (stat)
  );

  assign onehot = 4'b0001 << dec.drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel1_q <= 8'h00;
      sel2_q <= 8'h80;
      type_q <= '0;
      hld_q  <= 1'b0;
      chip_q <= 8'h00;
    end else if (cmd_wr) begin
      case (dec.kind)
        CK_SELECT: begin
          sel1_q    <= {onehot, retry[3:0]};
          sel2_q[7] <= ~onehot[3];
          type_q    <= dec.dtype;
          hld_q     <= dec.hld;
          chip_q    <= {6'b0, dec.drive};
        end
        CK_DESEL: begin
          sel1_q[7:4] <= 4'b0000;
          sel2_q[7]   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= 8'h00;
    else if (cmd_rd) rdata_q <= stat;
    else if (dat_rd) rdata_q <= (ptr == PTR_W'(CHIP_IDX)) ? chip_q : 8'h00;
  end

  assign host_rdata = rdata_q;
  assign sel1_o     = sel1_q;
  assign sel2_o     = sel2_q;
  assign drv_type_o = type_q;
  assign hld_en_o   = hld_q;
  assign reg_ptr_o  = ptr;
  assign irq_o      = stat[STAT_PEND];
  assign dma_busy_o = stat[STAT_DMA];

  a_r2_onehot_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel1_q[7:4]));
  a_r3_inverted_drive3: assert property (@(posedge clk) disable iff (rst)
    sel2_q[7] == ~sel1_q[7]);
  a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
    sel2_q[6:0] == 7'd0);
  a_r4_desel: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && dec.kind == CK_DESEL) |=> (sel1_q[7:4] == 4'b0000 && $stable(type_q)));
  a_r7_retry_hold: assert property (@(posedge clk) disable iff (rst)
    (!cmd_wr) |=> $stable(sel1_q));
endmodule

// File: tb/test_dskc_cmd_front.sv
module test_dskc_cmd_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 0, host_rd = 0, host_cmd = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       fin_valid = 0, fin_has_code = 0;
  logic [1:0] fin_code = 0;
  logic [7:0] sel1_o, sel2_o;
  logic [1:0] drv_type_o;
  logic       hld_en_o, irq_o, dma_busy_o;
  logic [3:0] reg_ptr_o;

  int nchk = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  dskc_cmd_front i_dskc_cmd_front (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_cmd(host_cmd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fin_valid(fin_valid), .fin_has_code(fin_has_code), .fin_code(fin_code),
    .sel1_o(sel1_o), .sel2_o(sel2_o), .drv_type_o(drv_type_o),
    .hld_en_o(hld_en_o), .reg_ptr_o(reg_ptr_o), .irq_o(irq_o),
    .dma_busy_o(dma_busy_o)
  );

  // {opcode, sel1, sel2, {0,type,hld}, ptr}; retry=0xA5, tcond=0x20, ptr starts at 10
  localparam logic [31:0] VEC [12] = '{
    32'h2015_800A, 32'h3B85_005A, 32'h0105_805A, 32'h2645_802A,
    32'h2D25_806A, 32'h4325_8063, 32'h4F25_806A, 32'h3785_003A,
    32'h4B85_003A, 32'h4A85_003A, 32'h4085_0030, 32'h1085_0030
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd_wr(input logic [7:0] op);
    host_wr = 1; host_cmd = 1; host_wdata = op;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic dat_wr(input logic [7:0] d);
    host_wr = 1; host_cmd = 0; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic cmd_side);
    host_rd = 1; host_cmd = cmd_side;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic fin(input logic hc, input logic [1:0] c);
    fin_valid = 1; fin_has_code = hc; fin_code = c;
    @(negedge clk);
    fin_valid = 0; fin_has_code = 0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sel1", sel1_o, 8'h00);
    check("R1 sel2", sel2_o, 8'h80);
    check("R1 irq/dma/hld", {irq_o, dma_busy_o, hld_en_o}, 3'b000);
    rst = 0;
    @(negedge clk);
    check("R1 ptr/type", {reg_ptr_o, drv_type_o}, 6'd0);

    // R6 program retry (8) and term-cond (9)
    cmd_wr(8'h48);
    dat_wr(8'hA5);
    check("R6 ptr advance", reg_ptr_o, 4'd9);
    dat_wr(8'h20);
    check("R6 ptr advance", reg_ptr_o, 4'd10);

    // R2 R3 R4 R5 table
    for (int k = 0; k < 12; k++) begin
      cmd_wr(VEC[k][31:24]);
      check("R2 R4 sel1", sel1_o, VEC[k][23:16]);
      check("R3 sel2", sel2_o, VEC[k][15:8]);
      check("R2 type/hld", {drv_type_o, hld_en_o}, VEC[k][6:4]);
      check("R5 ptr", reg_ptr_o, VEC[k][3:0]);
    end

    // R11 R12 interrupt read and clear
    check("R11 irq set", irq_o, 1'b1);
    rd(1);
    check("R12 status read", host_rdata, 8'hA0);
    check("R12 irq cleared", irq_o, 1'b0);
    rd(1);
    check("R12 done kept", host_rdata, 8'h20);

    // R8 chip status at index 8 (drive 3 from 0x37)
    cmd_wr(8'h48);
    rd(0);
    check("R8 chip status", host_rdata, 8'h03);
    check("R6 read advance", reg_ptr_o, 4'd9);
    rd(0);
    check("R8 other index", host_rdata, 8'h00);

    // R11 disable interrupts via register 9
    cmd_wr(8'h49);
    dat_wr(8'h00);
    rd(1);
    check("R12 pending before disable", host_rdata, 8'hA0);
    cmd_wr(8'h22);
    check("R11 no irq", irq_o, 1'b0);
    check("R2 select retry", sel1_o, 8'h45);
    rd(1);
    check("R9 done no pend", host_rdata, 8'h20);

    // R10 codes
    fin(1, 2'd2);
    rd(1);
    check("R10 seek code", host_rdata, 8'h30);
    fin(0, 2'd1);
    rd(1);
    check("R10 code kept", host_rdata, 8'h30);
    cmd_wr(8'h10);
    rd(1);
    check("R9 command keeps code", host_rdata, 8'h30);
    fin(1, 2'd3);
    rd(1);
    check("R10 data code", host_rdata, 8'h38);

    // R7 retry write does not reach sel1 until select
    cmd_wr(8'h48);
    dat_wr(8'h0C);
    check("R7 sel1 unchanged", sel1_o, 8'h45);
    cmd_wr(8'h21);
    check("R7 sel1 after select", sel1_o, 8'h2C);
    check("R3 sel2 drive1", sel2_o, 8'h80);

    // R6 saturation
    cmd_wr(8'h4A);
    dat_wr(8'h77);
    check("R6 saturate", reg_ptr_o, 4'd10);

    // R13 and R1 mid-run reset
    check("R13 dma low", dma_busy_o, 1'b0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 sel1 after reset", sel1_o, 8'h00);
    check("R1 sel2 after reset", sel2_o, 8'h80);
    check("R1 ptr after reset", reg_ptr_o, 4'd0);
    rd(1);
    check("R1 status after reset", host_rdata, 8'h00);
    summary();
  end
endmodule